// File: doc/BRIEF.md
# Virtually indexed, physically tagged L1 data cache lookup

This block is the lookup stage of a 4-way set-associative L1 data cache holding 16 KB in 32-byte lines (128 sets). The set index and the byte offset both lie inside the 12-bit page offset of the virtual address. Because those bits are the same before and after translation, the set is read from the arrays in the cycle the request is accepted, while the TLB beside the cache translates the page number. The stored tags are then compared with the 20-bit physical page number (PPN) that the TLB returns.

A request is accepted when `req_valid` and `req_ready` are both high. If the TLB reports a hit in that cycle, the PPN is taken at once and the hit word appears one cycle later. If the TLB has not yet translated, the stage holds the set it has read and waits for `tlb_hit`. On a tag miss the stage asks the next level for the line and waits for the response. It installs the line in the way chosen by a per-set tree pseudo-LRU and returns the requested word from the fill data. Only one request is in flight at a time.

The controller has four states. IDLE accepts a request. XLATE waits for the translation. TAGCHK compares the tags. FILL waits for the line from the next level. Its transitions are:

- IDLE to TAGCHK on accept with a TLB hit.
- IDLE to XLATE on accept without a TLB hit.
- XLATE to TAGCHK on a TLB hit.
- TAGCHK to IDLE on a tag match.
- TAGCHK to FILL on a tag mismatch.
- FILL to IDLE when the fill response arrives.

Top module: `vipt_l1_lookup`

## Requirements
- R1: After reset every line is invalid, `req_ready` is 1, and `rsp_valid` and `fill_req` are 0. The first access to any set is therefore a miss.
- R2: Bits [11:5] of `req_vofs` select the set and bits [4:2] select the 32-bit word within the line. Bits [1:0] have no effect on the returned word. These bits are captured at accept, so later changes on `req_vofs` have no effect on the request.
- R3: When a request is accepted and `tlb_hit` is 1 in the same cycle, a matching line gives `rsp_valid`=1 and `rsp_hit`=1 in the next cycle, with `rsp_data` holding the addressed word.
- R4: When a request is accepted with `tlb_hit`=0, `rsp_valid` and `req_ready` stay 0 for as long as `tlb_hit` stays 0. The PPN is taken in the first cycle `tlb_hit` is 1, and the tag result follows one cycle after that.
- R5: On a tag miss, `fill_req` rises the cycle after the tag check and stays 1, with `fill_addr` stable, until the cycle in which `fill_valid` is 1. `fill_addr` is {PPN, set index}, with the PPN in bits [26:7].
- R6: In the cycle `fill_valid` is 1, `rsp_valid`=1 and `rsp_hit`=0, and `rsp_data` is word k of `fill_line`, which is bits [32k+31:32k]. The line is installed valid with its tag, so a later access to it hits.
- R7: A hit requires a valid way whose tag equals the PPN taken from the TLB. The same set index with a different PPN misses, and the value on `tlb_ppn` while `tlb_hit` is 0 is not used.
- R8: Replacement is a per-set tree pseudo-LRU, reset to point at way 0, and both hits and fills update it. After four fills into a set, a fifth distinct line evicts the first-filled line. If the first-filled line was hit after the fourth fill, the fifth line evicts the second-filled line instead.
- R9: `req_ready` is 1 only in IDLE. A response or an accept always leaves the stage busy for at least the next cycle after an accept, and the stage is ready again in the cycle after a response.
- R10: A fill changes only the set it addresses. Lines in other sets keep hitting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_vofs | input | 12 | Page-offset bits of the virtual address |
| req_ready | output | 1 | Stage idle and able to accept |
| tlb_hit | input | 1 | TLB translation available this cycle |
| tlb_ppn | input | 20 | Physical page number from the TLB |
| rsp_valid | output | 1 | Response word valid |
| rsp_hit | output | 1 | Response came from a tag match (0: from a fill) |
| rsp_data | output | 32 | Addressed word |
| fill_req | output | 1 | Line request to the next level |
| fill_addr | output | 27 | Line address {PPN, set} |
| fill_valid | input | 1 | Line response from the next level |
| fill_line | input | 256 | Line data, word k at bits [32k+31:32k] |

## Verification
The bench first sends a cold miss to all 128 sets. The offsets and fill latencies vary, so the set-index and word-select fields are told apart from each other and from the fill address. It then reads every word of every set with the TLB answering after zero, one and two cycles. This shows that the early set read and the late tag compare use the right bits, and that the PPN is sampled only when `tlb_hit` is 1. A second PPN on an occupied set separates tag mismatch from index match. Two sets are then filled past their capacity, one with a hit before the overflow and one without. This tells the pseudo-LRU victim apart from plain first-in-first-out order. A last pass shows that untouched sets are unaffected.

// File: rtl/vipt_pkg.sv
`timescale 1ns/1ps
package vipt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XLATE,
        ST_TAGCHK,
        ST_FILL
    } lk_state_t;
endpackage

// File: rtl/vipt_store.sv
`timescale 1ns/1ps
// Tag, valid and data arrays with a registered per-way read of one word.
module vipt_store #(
    parameter int SETS   = 128,
    parameter int WAYS   = 4,
    parameter int TAG_W  = 20,
    parameter int LINE_W = 256,
    parameter int WORD_W = 32,
    localparam int IDX_W  = $clog2(SETS),
    localparam int WAY_W  = $clog2(WAYS),
    localparam int WSEL_W = $clog2(LINE_W / WORD_W)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rd_en,
    input  logic [IDX_W-1:0]              rd_set,
    input  logic [WSEL_W-1:0]             rd_word,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_set,
    input  logic [WAY_W-1:0]              wr_way,
    input  logic [TAG_W-1:0]              wr_tag,
    input  logic [LINE_W-1:0]             wr_line,
    output logic [WAYS-1:0]               q_vld,
    output logic [WAYS-1:0][TAG_W-1:0]    q_tag,
    output logic [WAYS-1:0][WORD_W-1:0]   q_word
);
    logic [WAYS-1:0]   vld_mem  [SETS];
    logic [TAG_W-1:0]  tag_mem  [SETS][WAYS];
    logic [LINE_W-1:0] data_mem [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) vld_mem[s] <= '0;
            q_vld <= '0;
        end else begin
            if (wr_en) vld_mem[wr_set][wr_way] <= 1'b1;
            if (rd_en) q_vld <= vld_mem[rd_set];
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_set][wr_way]  <= wr_tag;
            data_mem[wr_set][wr_way] <= wr_line;
        end
        if (rd_en) begin
            for (int w = 0; w < WAYS; w++) begin
                q_tag[w]  <= tag_mem[rd_set][w];
                q_word[w] <= data_mem[rd_set][w][rd_word*WORD_W +: WORD_W];
            end
        end
    end
endmodule

// File: rtl/vipt_plru.sv
`timescale 1ns/1ps
// Per-set tree pseudo-LRU: node bits point toward the less recently used half.
module vipt_plru #(
    parameter int SETS = 128,
    parameter int WAYS = 4,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS),
    localparam int LVLS  = WAY_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             touch_en,
    input  logic [WAY_W-1:0] touch_way,
    output logic [WAY_W-1:0] victim
);
    logic [WAYS-2:0] tree [SETS];
    logic [WAYS-2:0] cur, nxt;

    assign cur = tree[set_idx];

    always_comb begin
        int node;
        node = 0;
        for (int l = 0; l < LVLS; l++) node = 2 * node + 1 + int'(cur[node]);
        victim = WAY_W'(node - (WAYS - 1));
    end

    always_comb begin
        int node;
        nxt  = cur;
        node = 0;
        for (int l = 0; l < LVLS; l++) begin
            nxt[node] = ~touch_way[LVLS-1-l];
            node = 2 * node + 1 + int'(touch_way[LVLS-1-l]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) tree[s] <= '0;
        end else if (touch_en) begin
            tree[set_idx] <= nxt;
        end
    end
endmodule

// File: rtl/vipt_ctrl.sv
`timescale 1ns/1ps
module vipt_ctrl
    import vipt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic tlb_hit,
    input  logic tag_match,
    input  logic fill_valid,
    output logic req_ready,
    output logic rd_en,
    output logic ppn_ld,
    output logic hit_rsp,
    output logic fill_busy,
    output logic install
);
    lk_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (req_valid) state_nx = tlb_hit ? ST_TAGCHK : ST_XLATE;
            ST_XLATE:  if (tlb_hit)   state_nx = ST_TAGCHK;
            ST_TAGCHK: state_nx = tag_match ? ST_IDLE : ST_FILL;
            ST_FILL:   if (fill_valid) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready = 1'b0;
        rd_en     = 1'b0;
        ppn_ld    = 1'b0;
        hit_rsp   = 1'b0;
        fill_busy = 1'b0;
        install   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                req_ready = 1'b1;
                rd_en     = req_valid;
                ppn_ld    = req_valid && tlb_hit;
            end
            ST_XLATE:  ppn_ld  = tlb_hit;
            ST_TAGCHK: hit_rsp = tag_match;
            ST_FILL: begin
                fill_busy = 1'b1;
                install   = fill_valid;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/vipt_l1_lookup.sv
`timescale 1ns/1ps
module vipt_l1_lookup #(
    parameter int SETS       = 128,
    parameter int WAYS       = 4,
    parameter int LINE_BYTES = 32,
    parameter int WORD_W     = 32,
    parameter int PPN_W      = 20,
    localparam int IDX_W   = $clog2(SETS),
    localparam int OFF_W   = $clog2(LINE_BYTES),
    localparam int PGOFF_W = IDX_W + OFF_W,
    localparam int LINE_W  = LINE_BYTES * 8,
    localparam int WB      = $clog2(WORD_W / 8),
    localparam int WSEL_W  = OFF_W - WB,
    localparam int WAY_W   = $clog2(WAYS),
    localparam int FADDR_W = PPN_W + IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [PGOFF_W-1:0] req_vofs,
    output logic               req_ready,
    input  logic               tlb_hit,
    input  logic [PPN_W-1:0]   tlb_ppn,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic [WORD_W-1:0]  rsp_data,
    output logic               fill_req,
    output logic [FADDR_W-1:0] fill_addr,
    input  logic               fill_valid,
    input  logic [LINE_W-1:0]  fill_line
);
    logic [IDX_W-1:0]  idx_q;
    logic [WSEL_W-1:0] wsel_q;
    logic [PPN_W-1:0]  ppn_q;
    logic [IDX_W-1:0]  rd_set;
    logic [WSEL_W-1:0] rd_word;

    logic rd_en, ppn_ld, hit_rsp, fill_busy, install, tag_match;
    logic [WAYS-1:0]              q_vld;
    logic [WAYS-1:0][PPN_W-1:0]   q_tag;
    logic [WAYS-1:0][WORD_W-1:0]  q_word;
    logic [WAYS-1:0]              hit_vec;
    logic [WAY_W-1:0]             hit_way, victim, touch_way;

    assign rd_set  = req_vofs[PGOFF_W-1:OFF_W];
    assign rd_word = WSEL_W'(req_vofs[OFF_W-1:0] >> WB);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            wsel_q <= '0;
            ppn_q  <= '0;
        end else begin
            if (rd_en) begin
                idx_q  <= rd_set;
                wsel_q <= rd_word;
            end
            if (ppn_ld) ppn_q <= tlb_ppn;
        end
    end

    vipt_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .tlb_hit(tlb_hit),
        .tag_match(tag_match), .fill_valid(fill_valid), .req_ready(req_ready),
        .rd_en(rd_en), .ppn_ld(ppn_ld), .hit_rsp(hit_rsp),
        .fill_busy(fill_busy), .install(install)
    );

    vipt_store #(
        .SETS(SETS), .WAYS(WAYS), .TAG_W(PPN_W), .LINE_W(LINE_W), .WORD_W(WORD_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_set(rd_set), .rd_word(rd_word),
        .wr_en(install), .wr_set(idx_q), .wr_way(victim), .wr_tag(ppn_q),
        .wr_line(fill_line), .q_vld(q_vld), .q_tag(q_tag), .q_word(q_word)
    );

    vipt_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
        .clk(clk), .rst_n(rst_n), .set_idx(idx_q), .touch_en(hit_rsp || install),
        .touch_way(touch_way), .victim(victim)
    );

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            hit_vec[w] = q_vld[w] && (q_tag[w] == ppn_q);
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end
    assign tag_match = |hit_vec;
    assign touch_way = hit_rsp ? hit_way : victim;

    always_comb begin
        rsp_valid = hit_rsp || install;
        rsp_hit   = hit_rsp;
        if (hit_rsp)      rsp_data = q_word[hit_way];
        else if (install) rsp_data = fill_line[wsel_q*WORD_W +: WORD_W];
        else              rsp_data = '0;
    end

    assign fill_req  = fill_busy;
    assign fill_addr = {ppn_q, idx_q};
endmodule

// File: rtl/vipt_l1_lookup_chk.sv
`timescale 1ns/1ps
module vipt_l1_lookup_chk #(
    parameter int FADDR_W = 27
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic               tlb_hit,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic               fill_req,
    input logic [FADDR_W-1:0] fill_addr,
    input logic               fill_valid
);
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> req_ready && !rsp_valid && !fill_req);

    p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_ready_after_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> req_ready);

    p_no_rsp_untranslated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !tlb_hit) |=> !rsp_valid);

    p_fill_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !fill_valid) |=> fill_req && $stable(fill_addr));

    p_fill_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && fill_valid) |-> rsp_valid && !rsp_hit);

    p_hit_not_in_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> !fill_req && !req_ready);
endmodule

bind vipt_l1_lookup vipt_l1_lookup_chk #(.FADDR_W(FADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .tlb_hit(tlb_hit), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .fill_req(fill_req), .fill_addr(fill_addr), .fill_valid(fill_valid)
);

// File: tb/vipt_l1_lookup_test.sv
`timescale 1ns/1ps
module vipt_l1_lookup_test;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [11:0]  req_vofs = '0;
    logic         req_ready;
    logic         tlb_hit = 1'b0;
    logic [19:0]  tlb_ppn = '0;
    logic         rsp_valid, rsp_hit;
    logic [31:0]  rsp_data;
    logic         fill_req;
    logic [26:0]  fill_addr;
    logic         fill_valid = 1'b0;
    logic [255:0] fill_line = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vipt_l1_lookup uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vofs(req_vofs),
        .req_ready(req_ready), .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
        .fill_req(fill_req), .fill_addr(fill_addr), .fill_valid(fill_valid),
        .fill_line(fill_line)
    );

    function automatic logic [31:0] exp_word(logic [19:0] ppn, logic [6:0] set, int k);
        logic [2:0] kk;
        kk = 3'(k);
        return {ppn[11:0], set, 1'b1, kk, 1'b0, ppn[19:12]};
    endfunction

    function automatic logic [255:0] make_line(logic [26:0] a);
        logic [255:0] l;
        for (int k = 0; k < 8; k++) l[k*32 +: 32] = exp_word(a[26:7], a[6:0], k);
        return l;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // One full lookup; tdly = cycles TLB lags, flat = cycles fill lags.
    task automatic access(input logic [19:0] ppn, input logic [6:0] set, input int word,
                          input int byt, input int tdly, input bit exp_hit, input int flat);
        logic [31:0] ew;
        ew = exp_word(ppn, set, word);
        @(negedge clk);
        chk(req_ready == 1'b1, "R9 ready in idle", 32'(req_ready), 32'd1);
        req_valid = 1'b1;
        req_vofs  = {set, 3'(word), 2'(byt)};
        tlb_hit   = (tdly == 0);
        tlb_ppn   = (tdly == 0) ? ppn : ~ppn;
        @(negedge clk);
        req_valid = 1'b0;
        req_vofs  = ~req_vofs;
        tlb_ppn   = ~ppn;
        for (int i = 0; i < tdly; i++) begin
            #1;
            chk(!rsp_valid && !req_ready, "R4 stall while untranslated",
                {30'd0, rsp_valid, req_ready}, 32'd0);
            if (i == tdly - 1) begin
                tlb_hit = 1'b1;
                tlb_ppn = ppn;
            end
            @(negedge clk);
        end
        tlb_hit = 1'b0;
        tlb_ppn = ~ppn;
        #1;
        if (exp_hit) begin
            chk(rsp_valid && rsp_hit, "R3 hit response one cycle after tag input",
                {30'd0, rsp_valid, rsp_hit}, 32'd3);
            chk(rsp_data == ew, "R3/R2 hit word", rsp_data, ew);
        end else begin
            chk(!rsp_valid && !fill_req, "R7 miss gives no response at tag check",
                {30'd0, rsp_valid, fill_req}, 32'd0);
            @(negedge clk);
            #1;
            chk(fill_req == 1'b1, "R5 fill request after miss", 32'(fill_req), 32'd1);
            chk(fill_addr == {ppn, set}, "R5/R2 fill address", 32'(fill_addr), 32'({ppn, set}));
            for (int j = 0; j < flat; j++) begin
                @(negedge clk);
                #1;
                chk(fill_req && !rsp_valid && fill_addr == {ppn, set}, "R5 request held",
                    {30'd0, fill_req, rsp_valid}, 32'd2);
            end
            @(negedge clk);
            fill_valid = 1'b1;
            fill_line  = make_line(fill_addr);
            #1;
            chk(rsp_valid && !rsp_hit, "R6 fill response flags", {30'd0, rsp_valid, rsp_hit}, 32'd2);
            chk(rsp_data == ew, "R6 fill word", rsp_data, ew);
            @(negedge clk);
            fill_valid = 1'b0;
            fill_line  = '0;
        end
    endtask

    localparam logic [19:0] P0 = 20'hA5C31;
    localparam logic [19:0] P1 = 20'h5A3CE;

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(req_ready && !rsp_valid && !fill_req, "R1 reset state",
            {29'd0, req_ready, rsp_valid, fill_req}, 32'd4);
        rst_n = 1'b1;

        // R1 R5 R6: cold miss in every set, varied offsets and fill latency
        for (int s = 0; s < 128; s++)
            access(P0, 7'(s), s % 8, s % 4, s % 2, 1'b0, s % 3);

        // R2 R3 R4: every word of every set, TLB lag 0..2, byte lanes vary
        for (int s = 0; s < 128; s++)
            for (int w = 0; w < 8; w++)
                access(P0, 7'(s), w, (w + s) % 4, (s + w) % 3, 1'b1, 0);

        // R7: same index, different PPN misses; both then present
        access(P1, 7'd5, 3, 1, 1, 1'b0, 2);
        access(P1, 7'd5, 3, 2, 0, 1'b1, 0);
        access(P0, 7'd5, 6, 0, 2, 1'b1, 0);

        // R8: set 9 holds P0 (first fill); three more, then hit P0, then fifth evicts second
        access(20'h00B01, 7'd9, 0, 0, 0, 1'b0, 0);
        access(20'h00C02, 7'd9, 1, 0, 0, 1'b0, 1);
        access(20'h00D03, 7'd9, 2, 0, 0, 1'b0, 0);
        access(P0,        7'd9, 3, 0, 0, 1'b1, 0);
        access(20'h00E04, 7'd9, 4, 0, 0, 1'b0, 0);
        access(20'h00C02, 7'd9, 5, 0, 0, 1'b1, 0);
        access(20'h00D03, 7'd9, 6, 0, 0, 1'b1, 0);
        access(P0,        7'd9, 7, 0, 0, 1'b1, 0);
        access(20'h00E04, 7'd9, 0, 0, 0, 1'b1, 0);
        access(20'h00B01, 7'd9, 1, 0, 0, 1'b0, 0);

        // R8: set 10 with no intervening hit, fifth fill evicts the first-filled line
        access(20'h00B01, 7'd10, 0, 0, 0, 1'b0, 0);
        access(20'h00C02, 7'd10, 0, 0, 0, 1'b0, 0);
        access(20'h00D03, 7'd10, 0, 0, 0, 1'b0, 0);
        access(20'h00E04, 7'd10, 0, 0, 0, 1'b0, 0);
        access(20'h00B01, 7'd10, 2, 0, 0, 1'b1, 0);
        access(20'h00C02, 7'd10, 2, 0, 0, 1'b1, 0);
        access(20'h00D03, 7'd10, 2, 0, 0, 1'b1, 0);
        access(20'h00E04, 7'd10, 2, 0, 0, 1'b1, 0);
        access(P0,        7'd10, 2, 0, 0, 1'b0, 0);

        // R10: neighbouring sets untouched by fills above
        for (int s = 0; s < 128; s++)
            if (s != 9 && s != 10)
                access(P0, 7'(s), 7 - (s % 8), 3, 0, 1'b1, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R9 actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule